// File: doc/BRIEF.md
# Segmented Burst Store-and-Forward Buffer

This block sits between the fetch side and the delivery side of a DMA data mover and holds whole bursts in transit. Its storage is one memory cut into equal slots. Each slot holds exactly one burst, and each slot is as deep as the longest burst allowed. A burst always begins at beat zero of its own slot, even when the burst before it was short. The buffer records how long each stored burst is. The delivery side can therefore drain bursts of any length up to the slot depth and still receive a correct final-beat flag, with no beat counter of its own.

The fetch side first asks permission before it requests a burst. It pulses `src_req_issue` only while `src_req_permit` is high. The permit falls once the requested but not yet drained bursts fill every slot. Beats of a requested burst then arrive on `src_beat_valid` with a last-beat flag. There is no ready signal: every offered beat is written, because space was reserved when the burst was requested. The delivery side sees `dst_valid`, `dst_data` and `dst_last` and acknowledges with `dst_ready`. `dst_req_id` counts the completed bursts, and it advances in the same cycle that a burst becomes readable. Both sides run on one clock.

Top module: `burst_sf_buf`

## Requirements
- R1: After reset, `src_req_permit` is 1, `dst_valid` is 0, and `src_req_id` and `dst_req_id` are both 0.
- R2: `src_req_permit` is 0 exactly when NUM_SEG requested bursts (default 8) have not yet been fully drained on the delivery side. It returns to 1 in the cycle after the last beat of a burst is accepted on the delivery side.
- R3: A pulse on `src_req_issue` while `src_req_permit` is 0 has no effect, and `src_req_id` keeps its value. An accepted request increments `src_req_id`, which is an up-counter of log2(NUM_SEG)+1 bits that wraps.
- R4: Every burst is stored from the start of the next slot in request order. Bursts of mixed lengths therefore come out on the delivery side in order, with each beat's data unchanged.
- R5: `dst_req_id` and `dst_valid` stay unchanged while the final beat of a burst is offered. Both update in the cycle after the clock edge that writes that beat: `dst_req_id` increments by one and `dst_valid` rises if it was low.
- R6: `dst_last` is 1 on the real final beat of each stored burst, including bursts shorter than the slot depth. It is 0 on every other beat.
- R7: While `dst_valid` is 1 and `dst_ready` is 0, `dst_valid`, `dst_data` and `dst_last` hold their values.
- R8: `dst_valid` is 1 exactly when at least one completed burst has not yet been fully drained.
- R9: A burst of SEG_DEPTH beats (default 16), the full slot depth, is stored and drained intact, with `dst_last` on beat SEG_DEPTH-1.
- R10: Operation stays correct after the identifiers wrap around more than twice the slot count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req_issue | input | 1 | Fetch side requests one more burst |
| src_req_permit | output | 1 | A free slot exists for another request |
| src_req_id | output | ID_W | Count of accepted burst requests |
| src_beat_valid | input | 1 | A beat of the current burst is offered |
| src_beat_data | input | DATA_W | Beat data |
| src_beat_last | input | 1 | Offered beat ends its burst |
| dst_req_id | output | ID_W | Count of bursts that have become readable |
| dst_valid | output | 1 | A stored beat is presented |
| dst_ready | input | 1 | Delivery side takes the presented beat |
| dst_data | output | DATA_W | Presented beat data |
| dst_last | output | 1 | Presented beat is the final beat of its burst |

## Verification
The assertions rely on two rules for the fetch side. It offers beats only for a burst it has already requested, and it never lets a burst run past the slot depth without raising the last flag. The stimulus follows both rules by construction: every burst is written only after its request has been accepted, and every burst length is between 1 and SEG_DEPTH. Requests that are refused while the permit is low are still driven on purpose. The assertions bound occupancy against the request counter, so a refused request is allowed and must simply leave the counter unchanged.

// File: rtl/sf_buf_pkg.sv
package sf_buf_pkg;

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/sf_id_tracker.sv
module sf_id_tracker #(
  parameter int NUM_SEG = 8,
  localparam int SEG_W = $clog2(NUM_SEG),
  localparam int ID_W  = SEG_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_issue,
  input  logic            wr_done,
  input  logic            rd_done,
  output logic [ID_W-1:0] req_id,
  output logic [ID_W-1:0] wr_id,
  output logic [ID_W-1:0] rd_id,
  output logic            req_permit,
  output logic            bursts_ready,
  output logic            wr_pending
);

  logic [ID_W-1:0] req_id_n, wr_id_n, rd_id_n;
  logic            full;

  // Full: same slot index, opposite wrap bit. Counted against drained bursts.
  assign full         = (req_id[ID_W-1] != rd_id[ID_W-1]) &&
                        (req_id[SEG_W-1:0] == rd_id[SEG_W-1:0]);
  assign req_permit   = !full;
  assign bursts_ready = (wr_id != rd_id);
  assign wr_pending   = (wr_id != req_id);

  always_comb begin
    req_id_n = req_id;
    wr_id_n  = wr_id;
    rd_id_n  = rd_id;
    if (req_issue && req_permit) req_id_n = req_id + 1'b1;
    if (wr_done)                 wr_id_n  = wr_id + 1'b1;
    if (rd_done)                 rd_id_n  = rd_id + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_id <= '0;
      wr_id  <= '0;
      rd_id  <= '0;
    end else begin
      req_id <= req_id_n;
      wr_id  <= wr_id_n;
      rd_id  <= rd_id_n;
    end
  end

  // R2: never more bursts reserved than slots exist
  a_r2_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
    ID_W'(req_id - rd_id) <= ID_W'(NUM_SEG));

  // R5: the readable-burst count only moves after a completed write
  a_r5_id_needs_last: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_id != $past(wr_id)) |-> $past(wr_done));

endmodule

// File: rtl/sf_wr_ctrl.sv
module sf_wr_ctrl #(
  parameter int SEG_DEPTH = 16,
  localparam int BEAT_W = $clog2(SEG_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_valid,
  input  logic              beat_last,
  input  logic              wr_pending,
  output logic [BEAT_W-1:0] wr_beat,
  output logic              wr_done
);

  logic [BEAT_W-1:0] wr_beat_n;

  assign wr_done = beat_valid && beat_last;

  always_comb begin
    wr_beat_n = wr_beat;
    if (beat_valid) begin
      if (beat_last) wr_beat_n = '0;
      else           wr_beat_n = wr_beat + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_beat <= '0;
    else        wr_beat <= wr_beat_n;
  end

  // R4: beats only arrive for a burst that has been requested
  a_r4_beat_has_req: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> wr_pending);

  // R9: a burst may not run past the slot depth
  a_r9_burst_fits: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && (wr_beat == BEAT_W'(SEG_DEPTH - 1))) |-> beat_last);

endmodule

// File: rtl/sf_seg_mem.sv
module sf_seg_mem #(
  parameter int DATA_W    = 32,
  parameter int NUM_SEG   = 8,
  parameter int SEG_DEPTH = 16,
  localparam int SEG_W  = $clog2(NUM_SEG),
  localparam int BEAT_W = $clog2(SEG_DEPTH),
  localparam int WORDS  = NUM_SEG * SEG_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SEG_W-1:0]  w_seg,
  input  logic [BEAT_W-1:0] w_beat,
  input  logic [DATA_W-1:0] w_data,
  input  logic              len_we,
  input  logic [SEG_W-1:0]  r_seg,
  input  logic [BEAT_W-1:0] r_beat,
  output logic [DATA_W-1:0] r_data,
  output logic [BEAT_W-1:0] r_len
);

  logic [DATA_W-1:0] mem [WORDS];
  logic [BEAT_W-1:0] seg_len [NUM_SEG];

  // Data words carry no reset; they are read only after being written.
  always_ff @(posedge clk) begin
    if (we) mem[{w_seg, w_beat}] <= w_data;
  end

  // Final-beat index per slot, written with the last beat of a burst.
  generate
    for (genvar g = 0; g < NUM_SEG; g++) begin : g_len
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 seg_len[g] <= '0;
        else if (len_we && (w_seg == SEG_W'(g)))    seg_len[g] <= w_beat;
      end
    end
  endgenerate

  assign r_data = mem[{r_seg, r_beat}];
  assign r_len  = seg_len[r_seg];

endmodule

// File: rtl/sf_rd_ctrl.sv
module sf_rd_ctrl #(
  parameter int SEG_DEPTH = 16,
  localparam int BEAT_W = $clog2(SEG_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bursts_ready,
  input  logic              dst_ready,
  input  logic [BEAT_W-1:0] r_len,
  output logic [BEAT_W-1:0] rd_beat,
  output logic              dst_valid,
  output logic              dst_last,
  output logic              rd_done
);

  logic [BEAT_W-1:0] rd_beat_n;
  logic              take;

  assign dst_valid = bursts_ready;
  assign dst_last  = bursts_ready && (rd_beat == r_len);
  assign take      = dst_valid && dst_ready;
  assign rd_done   = take && dst_last;

  always_comb begin
    rd_beat_n = rd_beat;
    if (take) begin
      if (dst_last) rd_beat_n = '0;
      else          rd_beat_n = rd_beat + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_beat <= '0;
    else        rd_beat <= rd_beat_n;
  end

  // R6: the deepest beat of a slot is always the final one
  a_r6_full_seg_last: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && (rd_beat == BEAT_W'(SEG_DEPTH - 1))) |-> dst_last);

endmodule

// File: rtl/burst_sf_buf.sv
module burst_sf_buf
  import sf_buf_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_SEG   = 8,
  parameter int SEG_DEPTH = 16,
  localparam int SEG_W  = $clog2(NUM_SEG),
  localparam int BEAT_W = $clog2(SEG_DEPTH),
  localparam int ID_W   = SEG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_req_issue,
  output logic              src_req_permit,
  output logic [ID_W-1:0]   src_req_id,
  input  logic              src_beat_valid,
  input  logic [DATA_W-1:0] src_beat_data,
  input  logic              src_beat_last,
  output logic [ID_W-1:0]   dst_req_id,
  output logic              dst_valid,
  input  logic              dst_ready,
  output logic [DATA_W-1:0] dst_data,
  output logic              dst_last
);

  initial begin
    if (!is_pow2(NUM_SEG) || NUM_SEG < 2 || NUM_SEG > 32)
      $error("NUM_SEG must be a power of two from 2 to 32");
    if (!is_pow2(SEG_DEPTH) || SEG_DEPTH < 2)
      $error("SEG_DEPTH must be a power of two of at least 2");
  end

  logic [ID_W-1:0]   wr_id, rd_id;
  logic              bursts_ready, wr_pending, wr_done, rd_done;
  logic [BEAT_W-1:0] wr_beat, rd_beat, r_len;

  sf_id_tracker #(.NUM_SEG(NUM_SEG)) u_ids (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_issue    (src_req_issue),
    .wr_done      (wr_done),
    .rd_done      (rd_done),
    .req_id       (src_req_id),
    .wr_id        (wr_id),
    .rd_id        (rd_id),
    .req_permit   (src_req_permit),
    .bursts_ready (bursts_ready),
    .wr_pending   (wr_pending)
  );

  sf_wr_ctrl #(.SEG_DEPTH(SEG_DEPTH)) u_wr (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_valid (src_beat_valid),
    .beat_last  (src_beat_last),
    .wr_pending (wr_pending),
    .wr_beat    (wr_beat),
    .wr_done    (wr_done)
  );

  sf_seg_mem #(.DATA_W(DATA_W), .NUM_SEG(NUM_SEG), .SEG_DEPTH(SEG_DEPTH)) u_mem (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (src_beat_valid),
    .w_seg  (wr_id[SEG_W-1:0]),
    .w_beat (wr_beat),
    .w_data (src_beat_data),
    .len_we (wr_done),
    .r_seg  (rd_id[SEG_W-1:0]),
    .r_beat (rd_beat),
    .r_data (dst_data),
    .r_len  (r_len)
  );

  sf_rd_ctrl #(.SEG_DEPTH(SEG_DEPTH)) u_rd (
    .clk          (clk),
    .rst_n        (rst_n),
    .bursts_ready (bursts_ready),
    .dst_ready    (dst_ready),
    .r_len        (r_len),
    .rd_beat      (rd_beat),
    .dst_valid    (dst_valid),
    .dst_last     (dst_last),
    .rd_done      (rd_done)
  );

  assign dst_req_id = wr_id;

  // R7: a stalled beat is held steady
  a_r7_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && !dst_ready) |=> (dst_valid && $stable(dst_data) && $stable(dst_last)));

endmodule

// File: tb/burst_sf_buf_tb.sv
module burst_sf_buf_tb;

  localparam int DATA_W = 32;
  localparam int NSEG   = 8;
  localparam int DEPTH  = 16;
  localparam int ID_W   = $clog2(NSEG) + 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              src_req_issue;
  logic              src_req_permit;
  logic [ID_W-1:0]   src_req_id;
  logic              src_beat_valid;
  logic [DATA_W-1:0] src_beat_data;
  logic              src_beat_last;
  logic [ID_W-1:0]   dst_req_id;
  logic              dst_valid;
  logic              dst_ready;
  logic [DATA_W-1:0] dst_data;
  logic              dst_last;

  int n_chk  = 0;
  int n_fail = 0;
  int exp_req = 0;
  int exp_wr  = 0;

  always #5 clk = ~clk;

  burst_sf_buf #(.DATA_W(DATA_W), .NUM_SEG(NSEG), .SEG_DEPTH(DEPTH)) u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .src_req_issue  (src_req_issue),
    .src_req_permit (src_req_permit),
    .src_req_id     (src_req_id),
    .src_beat_valid (src_beat_valid),
    .src_beat_data  (src_beat_data),
    .src_beat_last  (src_beat_last),
    .dst_req_id     (dst_req_id),
    .dst_valid      (dst_valid),
    .dst_ready      (dst_ready),
    .dst_data       (dst_data),
    .dst_last       (dst_last)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input longint act, input longint exp);
    chk(act == exp, req, act, exp);
  endtask

  // all tasks start and end just after a falling edge
  task automatic issue();
    src_req_issue = 1'b1;
    @(negedge clk);
    src_req_issue = 1'b0;
    if (exp_req - (exp_wr - 0) >= 0) ; // bookkeeping done by caller
  endtask

  task automatic issue_ok();
    issue();
    exp_req = (exp_req + 1) % (2 * NSEG);
    chk_eq("R3 request counted", src_req_id, exp_req);
  endtask

  task automatic write_burst(input int len, input int base);
    for (int i = 0; i < len; i++) begin
      src_beat_valid = 1'b1;
      src_beat_data  = DATA_W'(base + i);
      src_beat_last  = (i == len - 1);
      @(negedge clk);
    end
    src_beat_valid = 1'b0;
    src_beat_last  = 1'b0;
    exp_wr = (exp_wr + 1) % (2 * NSEG);
  endtask

  task automatic drain_burst(input int len, input int base, input bit stall, input string req);
    for (int i = 0; i < len; i++) begin
      if (stall) begin
        dst_ready = 1'b0;
        #1;
        chk_eq({req, " stalled valid"}, dst_valid, 1);
        @(negedge clk);
        #1;
        chk_eq("R7 held data", dst_data, base + i);
        chk_eq("R7 held last", dst_last, (i == len - 1));
      end
      dst_ready = 1'b1;
      #1;
      chk_eq({req, " valid"}, dst_valid, 1);
      chk_eq({req, " data"},  dst_data, base + i);
      chk_eq({req, " last"},  dst_last, (i == len - 1));
      @(negedge clk);
    end
    dst_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk_eq("R1 permit", src_req_permit, 1);
    chk_eq("R1 valid", dst_valid, 0);
    chk_eq("R1 src id", src_req_id, 0);
    chk_eq("R1 dst id", dst_req_id, 0);
  endtask

  task automatic t_id_timing();
    issue_ok();
    for (int i = 0; i < 2; i++) begin
      src_beat_valid = 1'b1; src_beat_data = DATA_W'(100 + i); src_beat_last = 1'b0;
      @(negedge clk);
    end
    src_beat_valid = 1'b1; src_beat_data = 102; src_beat_last = 1'b1;
    #1;
    chk_eq("R5 id before last edge", dst_req_id, exp_wr);
    chk_eq("R5 valid before last edge", dst_valid, 0);
    @(negedge clk);
    src_beat_valid = 1'b0; src_beat_last = 1'b0;
    exp_wr = (exp_wr + 1) % (2 * NSEG);
    chk_eq("R5 id after last edge", dst_req_id, exp_wr);
    chk_eq("R5 valid after last edge", dst_valid, 1);
    drain_burst(3, 100, 1'b0, "R5");
    chk_eq("R8 idle after drain", dst_valid, 0);
  endtask

  task automatic t_short_bursts();
    for (int b = 0; b < 4; b++) issue_ok();
    write_burst(1, 200);
    write_burst(5, 300);
    write_burst(2, 400);
    write_burst(7, 500);
    chk_eq("R8 valid with bursts", dst_valid, 1);
    drain_burst(1, 200, 1'b0, "R6");
    drain_burst(5, 300, 1'b0, "R4");
    drain_burst(2, 400, 1'b1, "R6");
    drain_burst(7, 500, 1'b0, "R4");
    chk_eq("R8 idle", dst_valid, 0);
  endtask

  task automatic t_fill();
    for (int b = 0; b < NSEG; b++) begin
      chk_eq("R2 permit before full", src_req_permit, 1);
      issue_ok();
    end
    chk_eq("R2 permit when full", src_req_permit, 0);
    issue();
    chk_eq("R3 refused request ignored", src_req_id, exp_req);
    for (int b = 0; b < NSEG; b++) write_burst(b + 1, 1000 + 32 * b);
    chk_eq("R2 still full when stored", src_req_permit, 0);
    chk_eq("R5 all readable", dst_req_id, exp_wr);
    drain_burst(1, 1000, 1'b0, "R4");
    chk_eq("R2 permit after drain", src_req_permit, 1);
    for (int b = 1; b < NSEG; b++) drain_burst(b + 1, 1000 + 32 * b, 1'b0, "R4");
  endtask

  task automatic t_max_len();
    issue_ok();
    write_burst(DEPTH, 2000);
    drain_burst(DEPTH, 2000, 1'b1, "R9");
  endtask

  task automatic t_wrap();
    for (int k = 0; k < 3 * NSEG; k++) begin
      issue_ok();
      write_burst((k % DEPTH) + 1, 3000 + 64 * k);
      chk_eq("R10 id", dst_req_id, exp_wr);
      drain_burst((k % DEPTH) + 1, 3000 + 64 * k, 1'b0, "R10");
    end
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    src_req_issue = 1'b0;
    src_beat_valid = 1'b0;
    src_beat_data = '0;
    src_beat_last = 1'b0;
    dst_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_id_timing();
    t_short_bursts();
    t_fill();
    t_max_len();
    t_wrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule